// File: doc/BRIEF.md
# Bus-Inactivity Automatic Power-Down Controller

This block watches the strobes of a microcontroller bus and puts the attached memories to sleep when the bus has been quiet for a programmable number of ticks of a slow input clock. Software arms the feature through one 8-bit control register. While the block is asleep, the select lines to the primary memory, the secondary memory and the SRAM are held inactive, so any access made during that time reaches no memory. A transition on the address-latch-enable strobe, in either direction, restarts the quiet-period timer and brings the memories back.

A chip-select input provides a second way to hold the three memory selects inactive, independent of the timer. The turbo control bit in the same register is passed straight out to the programmable-logic path. Power-down never changes that output.

The address-latch-enable, chip-select and tick-clock inputs are asynchronous to the sampling clock `clk`. Each one passes through a two-flop synchronizer before any logic uses it.

Top module: `apd_ctrl`

## Requirements
- R1: While `rst_n` is low, `pd_flag` is 0, the inactivity count is 0, `reg_rdata` at address 0 reads 0, and every memory select equals its request.
- R2: A write with `reg_we`=1 and `reg_addr`=0 stores all 8 bits of `reg_wdata`, and address 0 reads them back unchanged on the next cycle. Writes to any other address are ignored, and any other address reads 0.
- R3: When control bit 1 is 0, `pd_flag` stays 0 and the inactivity count is held at 0.
- R4: When control bit 1 is 1, the count advances by one on each synchronized rising edge of `clkin`. `pd_flag` is 1 exactly while the count equals LIMIT (default 15), and the count saturates at LIMIT.
- R5: A synchronized change of `ale`, rising or falling, clears the count on the next clock edge. `pd_flag` is therefore 0 no later than the second `clk` rising edge after `ale` changes.
- R6: While `pd_flag` is 1, `prim_sel`, `sec_sel` and `sram_sel` are all 0, whatever the requests.
- R7: While the two most recent synchronized samples of `csi_n` are both 1, all three memory selects are 0, whatever the state of `pd_flag`.
- R8: `turbo_off` always equals control bit 3 and is unaffected by `pd_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkin | input | 1 | Slow tick clock for the inactivity count |
| ale | input | 1 | Address-latch-enable strobe from the bus |
| csi_n | input | 1 | Chip-select input; high forces the memories off |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address; the control register is at 0 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| prim_req | input | 1 | Decoded primary-memory select request |
| sec_req | input | 1 | Decoded secondary-memory select request |
| sram_req | input | 1 | Decoded SRAM select request |
| prim_sel | output | 1 | Gated primary-memory select |
| sec_sel | output | 1 | Gated secondary-memory select |
| sram_sel | output | 1 | Gated SRAM select |
| pd_flag | output | 1 | Power-down status |
| turbo_off | output | 1 | Turbo control for the programmable-logic path |

## Verification
On every cycle, the assertions check the following:
- the enable bit gates `pd_flag`;
- a synchronized address-latch-enable edge is followed by a low `pd_flag`;
- power-down and the chip-select path both hold all three selects low;
- the count only ever steps by one, clears, or holds at LIMIT.

The bench scenarios show the remaining behaviour:
- the exact timeout cycle and the wake latency, measured from a pin change;
- an address-latch-enable pulse one tick before timeout;
- a reset while asleep;
- register readback.

// File: rtl/apd_pkg.sv
package apd_pkg;
    localparam int CTRL_W    = 8;
    localparam int EN_BIT    = 1;
    localparam int TURBO_BIT = 3;
    localparam int NSEL      = 3;

    typedef struct packed {
        logic ale;
        logic csi_n;
        logic clkin;
    } bus_in_t;
endpackage

// File: rtl/apd_sync.sv
module apd_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] s1,
    output logic [W-1:0] s2
);
    typedef struct packed {
        logic [W-1:0] st1;
        logic [W-1:0] st2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.st1 = d;
        sync_d.st2 = sync_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign s1 = sync_q.st1;
    assign s2 = sync_q.st2;
endmodule

// File: rtl/apd_inact_cnt.sv
module apd_inact_cnt #(
    parameter int LIMIT = 15,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ale_s1,
    input  logic          ale_s2,
    input  logic          ck_s1,
    input  logic          ck_s2,
    output logic [CW-1:0] cnt,
    output logic          expired
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    ale_edge;
    logic    ck_rise;

    always_comb begin
        ale_edge = ale_s1 ^ ale_s2;
        ck_rise  = ck_s1 & ~ck_s2;
        st_d     = st_q;
        if (ale_edge || !en) begin
            st_d.cnt = '0;
        end else if (ck_rise && (st_q.cnt != CW'(LIMIT))) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign expired = en && (st_q.cnt == CW'(LIMIT));
endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
    import apd_pkg::*;
#(
    parameter int              LIMIT    = 15,
    parameter int              AW       = 2,
    parameter logic [AW-1:0]   REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clkin,
    input  logic              ale,
    input  logic              csi_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              prim_req,
    input  logic              sec_req,
    input  logic              sram_req,
    output logic              prim_sel,
    output logic              sec_sel,
    output logic              sram_sel,
    output logic              pd_flag,
    output logic              turbo_off
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } reg_st_t;

    bus_in_t          bus_raw, bus_s1, bus_s2;
    reg_st_t          reg_d, reg_q;
    logic             en;
    logic             ale_s1, ale_s2;
    logic             csi_off;
    logic [CW-1:0]    cnt;
    logic             block;
    logic [NSEL-1:0]  req_v, sel_v;

    assign bus_raw = '{ale: ale, csi_n: csi_n, clkin: clkin};

    apd_sync #(.W($bits(bus_in_t))) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_raw),
        .s1    (bus_s1),
        .s2    (bus_s2)
    );

    // control register
    always_comb begin
        reg_d = reg_q;
        if (reg_we && (reg_addr == REG_ADDR)) reg_d.ctrl = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign reg_rdata = (reg_addr == REG_ADDR) ? reg_q.ctrl : '0;
    assign en        = reg_q.ctrl[EN_BIT];
    assign turbo_off = reg_q.ctrl[TURBO_BIT];

    assign ale_s1  = bus_s1.ale;
    assign ale_s2  = bus_s2.ale;
    assign csi_off = bus_s1.csi_n & bus_s2.csi_n;

    apd_inact_cnt #(.LIMIT(LIMIT)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .ale_s1  (ale_s1),
        .ale_s2  (ale_s2),
        .ck_s1   (bus_s1.clkin),
        .ck_s2   (bus_s2.clkin),
        .cnt     (cnt),
        .expired (pd_flag)
    );

    // memory select gating
    assign block = pd_flag | csi_off;
    assign req_v = {sram_req, sec_req, prim_req};

    for (genvar i = 0; i < NSEL; i++) begin : g_gate
        assign sel_v[i] = req_v[i] & ~block;
    end

    assign prim_sel = sel_v[0];
    assign sec_sel  = sel_v[1];
    assign sram_sel = sel_v[2];
endmodule

// File: rtl/apd_ctrl_chk.sv
module apd_ctrl_chk #(
    parameter int LIMIT = 15,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          pd_flag,
    input logic          ale_s1,
    input logic          ale_s2,
    input logic          csi_off,
    input logic          prim_sel,
    input logic          sec_sel,
    input logic          sram_sel,
    input logic [CW-1:0] cnt
);
    p_pd_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pd_flag);

    p_ale_wakes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_s1 != ale_s2) |=> !pd_flag);

    p_pd_blocks_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pd_flag |-> !(prim_sel || sec_sel || sram_sel));

    p_csi_blocks_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        csi_off |-> !(prim_sel || sec_sel || sram_sel));

    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> ((cnt == '0) || ((cnt - $past(cnt)) == CW'(1))));

    p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == CW'(LIMIT)) && en && (ale_s1 == ale_s2)) |=> (cnt == CW'(LIMIT)));
endmodule

bind apd_ctrl apd_ctrl_chk #(.LIMIT(LIMIT), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pd_flag  (pd_flag),
    .ale_s1   (ale_s1),
    .ale_s2   (ale_s2),
    .csi_off  (csi_off),
    .prim_sel (prim_sel),
    .sec_sel  (sec_sel),
    .sram_sel (sram_sel),
    .cnt      (cnt)
);

// File: tb/tb_apd_ctrl.sv
module tb_apd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LIM        = 15;
    localparam int AW         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clkin = 1'b0, ale = 1'b0, csi_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          prim_req = 1'b0, sec_req = 1'b0, sram_req = 1'b0;
    logic          prim_sel, sec_sel, sram_sel, pd_flag, turbo_off;

    int checks = 0;
    int errors = 0;

    apd_ctrl #(.LIMIT(LIM), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .clkin(clkin), .ale(ale), .csi_n(csi_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .prim_req(prim_req), .sec_req(sec_req),
        .sram_req(sram_req), .prim_sel(prim_sel), .sec_sel(sec_sel),
        .sram_sel(sram_sel), .pd_flag(pd_flag), .turbo_off(turbo_off)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // requirement model
    logic m_a1, m_a2, m_c1, m_c2, m_s1, m_s2;
    logic [7:0] m_reg;
    int m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_a1 <= 0; m_a2 <= 0; m_c1 <= 0; m_c2 <= 0; m_s1 <= 0; m_s2 <= 0;
            m_reg <= '0; m_cnt <= 0;
        end else begin
            m_a1 <= ale;   m_a2 <= m_a1;
            m_c1 <= clkin; m_c2 <= m_c1;
            m_s1 <= csi_n; m_s2 <= m_s1;
            if (reg_we && reg_addr == 0) m_reg <= reg_wdata;
            if ((m_a1 != m_a2) || !m_reg[1]) m_cnt <= 0;
            else if (m_c1 && !m_c2 && m_cnt != LIM) m_cnt <= m_cnt + 1;
        end
    end

    function automatic logic exp_pd();
        return m_reg[1] && (m_cnt == LIM);
    endfunction

    function automatic logic exp_sel(input logic req);
        return req && !exp_pd() && !(m_s1 && m_s2);
    endfunction

    function automatic logic [7:0] exp_rdata();
        return (reg_addr == 0) ? m_reg : 8'h00;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(pd_flag == exp_pd(), m_reg[1] ? "R4 pd_flag" : "R3 pd_flag", pd_flag, exp_pd());
        chk({sram_sel, sec_sel, prim_sel} ==
            {exp_sel(sram_req), exp_sel(sec_req), exp_sel(prim_req)}, "R6 selects",
            {sram_sel, sec_sel, prim_sel},
            {exp_sel(sram_req), exp_sel(sec_req), exp_sel(prim_req)});
        chk(reg_rdata == exp_rdata(), "R2 rdata", reg_rdata, exp_rdata());
        chk(turbo_off == m_reg[3], "R8 turbo_off", turbo_off, m_reg[3]);
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
        reg_we = 1; reg_addr = a; reg_wdata = v;
        step();
        reg_we = 0; reg_addr = 0;
    endtask

    task automatic tick_until_pd();
        for (int i = 0; i < 80 && !exp_pd(); i++) begin
            clkin = ~clkin;
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        prim_req = 1; sec_req = 1; sram_req = 1;
        repeat (3) @(negedge clk);
        chk(pd_flag == 0, "R1 pd in reset", pd_flag, 0);
        chk(reg_rdata == 0, "R1 rdata in reset", reg_rdata, 0);
        chk({sram_sel, sec_sel, prim_sel} == 3'b111, "R1 selects in reset",
            {sram_sel, sec_sel, prim_sel}, 3'b111);
        rst_n = 1;
        step();

        // R2 readback and ignored address
        wr(0, 8'h0A);
        step();
        chk(reg_rdata == 8'h0A, "R2 readback", reg_rdata, 8'h0A);
        chk(turbo_off == 1, "R8 turbo from bit 3", turbo_off, 1);
        wr(1, 8'hFF);
        reg_addr = 1;
        @(negedge clk);
        chk(reg_rdata == 0, "R2 other address reads 0", reg_rdata, 0);
        reg_addr = 0;
        step();
        chk(reg_rdata == 8'h0A, "R2 other address write ignored", reg_rdata, 8'h0A);

        // R4 timeout, R6 gating, R8 unaffected
        tick_until_pd();
        chk(pd_flag == 1, "R4 timeout reached", pd_flag, 1);
        chk({sram_sel, sec_sel, prim_sel} == 0, "R6 selects off in power-down",
            {sram_sel, sec_sel, prim_sel}, 0);
        chk(turbo_off == 1, "R8 turbo kept in power-down", turbo_off, 1);
        repeat (6) begin clkin = ~clkin; step(); end
        chk(pd_flag == 1, "R4 saturated", pd_flag, 1);

        // R5 wake within two clocks
        ale = ~ale;
        step(); step();
        chk(pd_flag == 0, "R5 wake after ale edge", pd_flag, 0);

        // R5 ale pulse one tick before timeout
        for (int i = 0; i < 80 && m_cnt != LIM - 1; i++) begin clkin = ~clkin; step(); end
        ale = ~ale;
        step(); step();
        chk(pd_flag == 0, "R5 ale before timeout", pd_flag, 0);
        chk(m_cnt < 2, "R5 count restarted", m_cnt, 0);

        // R3 disabled
        wr(0, 8'h08);
        repeat (60) begin clkin = ~clkin; step(); end
        chk(pd_flag == 0, "R3 disabled never powers down", pd_flag, 0);

        // R7 chip-select path
        wr(0, 8'h0A);
        csi_n = 1;
        step(); step();
        chk({sram_sel, sec_sel, prim_sel} == 0, "R7 csi forces selects off",
            {sram_sel, sec_sel, prim_sel}, 0);
        csi_n = 0;
        step(); step();

        // R1 reset during power-down
        tick_until_pd();
        chk(pd_flag == 1, "R4 timeout before reset", pd_flag, 1);
        rst_n = 0;
        #1;
        chk(pd_flag == 0, "R1 reset clears power-down", pd_flag, 0);
        chk(reg_rdata == 0, "R1 reset clears register", reg_rdata, 0);
        step();
        rst_n = 1;
        wr(0, 8'h02);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            clkin    = 1'($urandom % 2);
            if ($urandom % 48 == 0) ale = ~ale;
            csi_n    = ($urandom % 25 == 0);
            prim_req = 1'($urandom % 2);
            sec_req  = 1'($urandom % 2);
            sram_req = 1'($urandom % 2);
            if ($urandom % 150 == 0) begin
                reg_we    = 1;
                reg_addr  = AW'($urandom % 4);
                reg_wdata = 8'($urandom);
                if ($urandom % 5 != 0) reg_wdata[1] = 1'b1;
            end else begin
                reg_we   = 0;
                reg_addr = AW'($urandom % 4);
            end
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule